// File: doc/BRIEF.md
# Dual-Interrupt 32-Pin GPIO Bank

This block is a bank of 32 general-purpose pins behind a 32-bit register interface. Each pin is an input or an output. An input pin can raise events on a rising edge, a falling edge, a low level or a high level, in any combination. Every event is latched into two independent status registers. Each status register has its own enable register and its own interrupt output, so two processors can service the same pins separately.

Set and clear alias addresses let software change single bits of the interrupt enables, the wakeup enable and the output data without a read-modify-write. A one-cycle wakeup request is raised when a wake-enabled pin has an edge event, but only while the system configuration permits it. A configuration bit performs a soft reset of the bank. The debounce registers are storage only.

The register port has two valid/ready channels. A command (read or write) is taken when `cmd_valid` and `cmd_ready` are both high. A read returns one beat on the response channel. The response is held unchanged while `rsp_ready` is low, and no new command is taken while a response waits. Writes return nothing.

Top module: `gpio_dualirq_bank`

## Requirements
- R1: The register map uses byte offsets, and address bits [1:0] are ignored. 0x00 identity (reads the REV_ID parameter), 0x10 system config, 0x14 system status, 0x18/0x1C status/enable of line 1, 0x20 wakeup enable, 0x28/0x2C status/enable of line 2, 0x30 control, 0x34 output enable, 0x38 pin levels, 0x3C output data, 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect, 0x50 debounce enable, 0x54 debounce time. A read of an alias address returns its base register. Writes to 0x00, 0x14 and 0x38 change nothing. An unmapped read returns 0.
- R2: `cmd_ready` is high exactly when no response is pending or the pending one is being taken. A pending response keeps `rsp_valid` high and `rsp_rdata` stable while `rsp_ready` is low.
- R3: An output-enable bit of 1 makes the pin an input. The register drives `pin_oe_n` directly, and it is all ones after reset. `pin_out` is the output data register. Reading 0x38 returns the pin levels sampled one clock earlier.
- R4: Alias writes change only the bits written as 1. 0x60/0x64 clear/set the line-1 enable, 0x70/0x74 clear/set the line-2 enable, 0x80/0x84 clear/set the wakeup enable, and 0x90/0x94 clear/set the output data.
- R5: An input pin has an event on a 0-to-1 change if its rising or high-level detect bit is set, and on a 1-to-0 change if its falling or low-level detect bit is set. An output pin never has an event.
- R6: An event sets the pin's bit in both status registers at the clock edge that samples the change. Each interrupt output is high exactly when its status ANDed with its enable is nonzero.
- R7: Writing 1s to a status register clears those bits. Bits written as 0, and the other line's status, are unchanged. An input pin whose sampled level matches an enabled level detect sets its status bit again at once. This also happens in the cycle after the output-enable or level-detect registers change.
- R8: System config keeps only bits 4, 3, 2 and 0 (mask 0x1D). Control keeps bits [2:0]. Debounce time keeps bits [7:0]. Debounce enable keeps all 32 bits.
- R9: `wake` pulses for one cycle after an edge event on a pin whose wakeup-enable bit is set. This needs config bit 2 set and the idle field, config bits [4:3], equal to 1 or 2. The value 3 is invalid and never wakes.
- R10: A config write with bit 1 set is a soft reset. Config takes the written value under the 0x1D mask. Output enable returns to all ones. Every other writable register and both status registers return to 0.
- R11: System status bit 0 reads 1 once reset has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when high with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Byte offset of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data offered |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 32 | Pin levels, synchronous to clk |
| pin_out | output | 32 | Output data register |
| pin_oe_n | output | 32 | Output enable, 1 = pin is an input |
| irq1 | output | 1 | Interrupt line 1 |
| irq2 | output | 1 | Interrupt line 2 |
| wake | output | 1 | One-cycle wakeup request |

## Verification
The bench checks that clearing one status register leaves the other line's status and interrupt intact. A design sharing one status would drop both. It clears a level-detect bit while the pin still holds the level and expects the bit back at once. It clears an edge-only bit and expects it to stay clear. A design re-evaluating edges, or not re-evaluating levels, fails one of the two. It steps the wake gate through idle values 0, 1 and 3, with config bit 2 off and with the wake enable off, to catch a wakeup that ignores any of its qualifiers. It also reads the registers back after a soft reset to catch the output enable or a status bit escaping the clear. Throughout, the response channel is stalled at random-looking points, so a response that is lost or changes under back-pressure breaks the read order.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_IDENT  = 8'h00;
  localparam logic [7:0] A_SYSCFG = 8'h10;
  localparam logic [7:0] A_SYSSTA = 8'h14;
  localparam logic [7:0] A_ST1    = 8'h18;
  localparam logic [7:0] A_EN1    = 8'h1C;
  localparam logic [7:0] A_WKEN   = 8'h20;
  localparam logic [7:0] A_ST2    = 8'h28;
  localparam logic [7:0] A_EN2    = 8'h2C;
  localparam logic [7:0] A_CTRL   = 8'h30;
  localparam logic [7:0] A_OE     = 8'h34;
  localparam logic [7:0] A_DIN    = 8'h38;
  localparam logic [7:0] A_DOUT   = 8'h3C;
  localparam logic [7:0] A_LOLVL  = 8'h40;
  localparam logic [7:0] A_HILVL  = 8'h44;
  localparam logic [7:0] A_RISE   = 8'h48;
  localparam logic [7:0] A_FALL   = 8'h4C;
  localparam logic [7:0] A_DBEN   = 8'h50;
  localparam logic [7:0] A_DBTIME = 8'h54;
  localparam logic [7:0] A_EN1CLR = 8'h60;
  localparam logic [7:0] A_EN1SET = 8'h64;
  localparam logic [7:0] A_EN2CLR = 8'h70;
  localparam logic [7:0] A_EN2SET = 8'h74;
  localparam logic [7:0] A_WKCLR  = 8'h80;
  localparam logic [7:0] A_WKSET  = 8'h84;
  localparam logic [7:0] A_DOCLR  = 8'h90;
  localparam logic [7:0] A_DOSET  = 8'h94;

  localparam int         CFG_W    = 5;
  localparam logic [4:0] CFG_KEEP = 5'b11101;
  localparam int         CTRL_W   = 3;
  localparam int         DBT_W    = 8;
  localparam int         NLINE    = 2;

  function automatic logic [7:0] st_ofs(input int line);
    return (line == 0) ? A_ST1 : A_ST2;
  endfunction
  function automatic logic [7:0] en_ofs(input int line);
    return (line == 0) ? A_EN1 : A_EN2;
  endfunction
  function automatic logic [7:0] enclr_ofs(input int line);
    return (line == 0) ? A_EN1CLR : A_EN2CLR;
  endfunction
  function automatic logic [7:0] enset_ofs(input int line);
    return (line == 0) ? A_EN1SET : A_EN2SET;
  endfunction

  function automatic logic idle_allows_wake(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction
endpackage

// File: rtl/gpio_cmd_port.sv
module gpio_cmd_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] rd_value
);
  logic          pend_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign cmd_ready = !pend_q || rsp_ready;
  assign take      = cmd_valid && cmd_ready;
  assign acc_wr    = take && cmd_write;
  assign acc_addr  = cmd_addr & ~AW'(3);
  assign acc_wdata = cmd_wdata;
  assign rsp_valid = pend_q;
  assign rsp_rdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (take && !cmd_write) begin
      pend_q <= 1'b1;
      data_q <= rd_value;
    end else if (rsp_ready) begin
      pend_q <= 1'b0;
    end
  end

  // R2: a stalled response neither drops nor changes
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rsp_ready) |=> (pend_q && $stable(data_q)));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] is_input,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] hi_en,
  input  logic [NPIN-1:0] lo_en,
  output logic [NPIN-1:0] level_q,
  output logic [NPIN-1:0] edge_evt,
  output logic [NPIN-1:0] level_hit
);
  logic [NPIN-1:0] lv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lv_q <= '0;
    else        lv_q <= pin_in;
  end

  assign level_q = lv_q;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic up, down;
    assign up           = pin_in[p] & ~lv_q[p];
    assign down         = ~pin_in[p] & lv_q[p];
    assign edge_evt[p]  = is_input[p] &
                          ((up & (rise_en[p] | hi_en[p])) | (down & (fall_en[p] | lo_en[p])));
    assign level_hit[p] = is_input[p] & (lv_q[p] ? hi_en[p] : lo_en[p]);
  end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic [NPIN-1:0] set_bits,
  input  logic            clr_wr,
  input  logic            en_wr,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] status,
  output logic [NPIN-1:0] enable,
  output logic            irq
);
  logic [NPIN-1:0] st_q, en_q, clr_mask;

  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else if (soft_clr) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_mask) | set_bits;
      if (en_wr)       en_q <= wdata;
      else if (en_set) en_q <= en_q | wdata;
      else if (en_clr) en_q <= en_q & ~wdata;
    end
  end

  assign status = st_q;
  assign enable = en_q;
  assign irq    = |(st_q & en_q);

  // R7: a full clear with nothing re-asserting leaves the status empty
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (&wdata) && !soft_clr && !(|set_bits)) |=> (st_q == '0));
endmodule

// File: rtl/gpio_dualirq_bank.sv
module gpio_dualirq_bank
  import gpio_bank_pkg::*;
#(
  parameter int         NPIN   = 32,
  parameter logic [7:0] REV_ID = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe_n,
  output logic              irq1,
  output logic              irq2,
  output logic              wake
);
  logic              acc_wr;
  logic [ADDR_W-1:0] ofs;
  logic [DW-1:0]     wd;
  logic [DW-1:0]     rd_value;
  logic [NPIN-1:0]   wdn;

  logic [CFG_W-1:0]  cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DBT_W-1:0]  dbt_q;
  logic              done_q, wake_q;
  logic [NPIN-1:0]   wken_q, oe_q, dout_q, lo_q, hi_q, rise_q, fall_q, dben_q;

  logic [NPIN-1:0]   level_q, edge_evt, level_hit, set_bits;
  logic [NPIN-1:0]   st_w [NLINE];
  logic [NPIN-1:0]   en_w [NLINE];
  logic [NLINE-1:0]  irq_w;
  logic              soft_rst;

  gpio_cmd_port #(.AW(ADDR_W), .DW(DW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .acc_wr   (acc_wr),
    .acc_addr (ofs),
    .acc_wdata(wd),
    .rd_value (rd_value)
  );

  assign wdn      = wd[NPIN-1:0];
  assign soft_rst = acc_wr && (ofs == A_SYSCFG) && wd[1];

  gpio_evt_detect #(.NPIN(NPIN)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .is_input (oe_q),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .hi_en    (hi_q),
    .lo_en    (lo_q),
    .level_q  (level_q),
    .edge_evt (edge_evt),
    .level_hit(level_hit)
  );

  assign set_bits = edge_evt | level_hit;

  for (genvar li = 0; li < NLINE; li++) begin : g_line
    gpio_irq_line #(.NPIN(NPIN)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_clr(soft_rst),
      .set_bits(set_bits),
      .clr_wr  (acc_wr && (ofs == st_ofs(li))),
      .en_wr   (acc_wr && (ofs == en_ofs(li))),
      .en_set  (acc_wr && (ofs == enset_ofs(li))),
      .en_clr  (acc_wr && (ofs == enclr_ofs(li))),
      .wdata   (wdn),
      .status  (st_w[li]),
      .enable  (en_w[li]),
      .irq     (irq_w[li])
    );
  end

  assign irq1 = irq_w[0];
  assign irq2 = irq_w[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      dbt_q  <= '0;
      done_q <= 1'b0;
      wken_q <= '0;
      oe_q   <= '1;
      dout_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dben_q <= '0;
    end else if (soft_rst) begin
      cfg_q  <= wd[CFG_W-1:0] & CFG_KEEP;
      ctrl_q <= '0;
      dbt_q  <= '0;
      done_q <= 1'b0;
      wken_q <= '0;
      oe_q   <= '1;
      dout_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dben_q <= '0;
    end else begin
      done_q <= 1'b1;
      if (acc_wr) begin
        case (ofs)
          A_SYSCFG: cfg_q  <= wd[CFG_W-1:0] & CFG_KEEP;
          A_CTRL:   ctrl_q <= wd[CTRL_W-1:0];
          A_DBTIME: dbt_q  <= wd[DBT_W-1:0];
          A_WKEN:   wken_q <= wdn;
          A_WKSET:  wken_q <= wken_q | wdn;
          A_WKCLR:  wken_q <= wken_q & ~wdn;
          A_OE:     oe_q   <= wdn;
          A_DOUT:   dout_q <= wdn;
          A_DOSET:  dout_q <= dout_q | wdn;
          A_DOCLR:  dout_q <= dout_q & ~wdn;
          A_LOLVL:  lo_q   <= wdn;
          A_HILVL:  hi_q   <= wdn;
          A_RISE:   rise_q <= wdn;
          A_FALL:   fall_q <= wdn;
          A_DBEN:   dben_q <= wdn;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (soft_rst) wake_q <= 1'b0;
    else               wake_q <= cfg_q[2] && idle_allows_wake(cfg_q[4:3]) &&
                                 (|(edge_evt & wken_q));
  end

  assign wake     = wake_q;
  assign pin_out  = dout_q;
  assign pin_oe_n = oe_q;

  always_comb begin
    rd_value = '0;
    case (ofs)
      A_IDENT:             rd_value = DW'(REV_ID);
      A_SYSCFG:            rd_value = DW'(cfg_q);
      A_SYSSTA:            rd_value = DW'(done_q);
      A_ST1:               rd_value = DW'(st_w[0]);
      A_ST2:               rd_value = DW'(st_w[1]);
      A_EN1, A_EN1CLR, A_EN1SET: rd_value = DW'(en_w[0]);
      A_EN2, A_EN2CLR, A_EN2SET: rd_value = DW'(en_w[1]);
      A_WKEN, A_WKCLR, A_WKSET:  rd_value = DW'(wken_q);
      A_DOUT, A_DOCLR, A_DOSET:  rd_value = DW'(dout_q);
      A_CTRL:              rd_value = DW'(ctrl_q);
      A_OE:                rd_value = DW'(oe_q);
      A_DIN:               rd_value = DW'(level_q);
      A_LOLVL:             rd_value = DW'(lo_q);
      A_HILVL:             rd_value = DW'(hi_q);
      A_RISE:              rd_value = DW'(rise_q);
      A_FALL:              rd_value = DW'(fall_q);
      A_DBEN:              rd_value = DW'(dben_q);
      A_DBTIME:            rd_value = DW'(dbt_q);
      default:             rd_value = '0;
    endcase
  end

  // R6: an edge event lands in both status registers
  p_evt_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|edge_evt) && !soft_rst) |=>
      (((st_w[0] & $past(edge_evt)) == $past(edge_evt)) &&
       ((st_w[1] & $past(edge_evt)) == $past(edge_evt))));

  // R9: no wake request unless config permits it
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[2] || !idle_allows_wake(cfg_q[4:3])) |=> !wake_q);

  // R10: soft reset returns pins to inputs with zero output data
  p_soft_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((pin_oe_n == '1) && (pin_out == '0) && !irq1 && !irq2));
endmodule

// File: tb/sim_gpio_dualirq_bank.sv
module sim_gpio_dualirq_bank;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [7:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in, pin_out, pin_oe_n;
  logic        irq1, irq2, wake;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  gpio_dualirq_bank #(.NPIN(32), .REV_ID(8'h18)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n),
    .irq1(irq1), .irq2(irq2), .wake(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, 32'h0);
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic nap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // back-pressure on the response channel, changed just after each edge
  initial begin
    int sc = 0;
    rsp_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      sc++;
      rsp_ready = ((sc % 5) != 3) && ((sc % 7) != 2);
    end
  end

  // monitor: pop the expected value for each response beat
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    pin_in = '0;
    nap(3);
    check("R3 reset pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    nap(2);
    check("R6 reset irq1", {31'b0, irq1}, 32'h0);
    check("R6 reset irq2", {31'b0, irq2}, 32'h0);
    check("R9 reset wake", {31'b0, wake}, 32'h0);
    rd(8'h14, 32'h1, "R11 status done");
    rd(8'h00, 32'h18, "R1 identity");
    rd(8'h34, 32'hFFFF_FFFF, "R3 oe reset");

    // R1 ignored writes and unmapped read
    wr(8'h00, 32'h55); rd(8'h00, 32'h18, "R1 identity write ignored");
    wr(8'h38, 32'h1234); rd(8'h38, 32'h0, "R1 pin level write ignored");
    wr(8'h14, 32'h0); rd(8'h14, 32'h1, "R1 status write ignored");
    rd(8'hFC, 32'h0, "R1 unmapped read");
    rd(8'h1A, 32'h0, "R1 low address bits ignored");

    // R3 / R4 output data and aliases
    wr(8'h3C, 32'h0000_00F0);
    check("R3 pin_out", pin_out, 32'h0000_00F0);
    wr(8'h94, 32'h0000_0F00);
    rd(8'h3C, 32'h0000_0FF0, "R4 data set alias");
    wr(8'h90, 32'h0000_0030);
    check("R4 data clear alias pin_out", pin_out, 32'h0000_0FC0);
    rd(8'h94, 32'h0000_0FC0, "R1 alias read data");
    wr(8'h64, 32'h3); wr(8'h60, 32'h1);
    rd(8'h1C, 32'h2, "R4 line1 enable aliases");
    wr(8'h74, 32'h5); wr(8'h70, 32'h4);
    rd(8'h74, 32'h1, "R4 line2 enable aliases");
    wr(8'h84, 32'hF0); wr(8'h80, 32'h30);
    rd(8'h20, 32'hC0, "R4 wake enable aliases");
    wr(8'h3C, 32'h0); wr(8'h20, 32'h0);

    // R3 pin levels
    pin_in = 32'hA5A5_0000;
    nap(2);
    rd(8'h38, 32'hA5A5_0000, "R3 pin levels");

    // R5 / R6 / R7 edge events
    wr(8'h48, 32'h1); wr(8'h4C, 32'h2);
    wr(8'h1C, 32'h0000_FFFF); wr(8'h2C, 32'h0);
    setpin(0, 1'b1);
    nap(1);
    check("R6 irq1 on rise", {31'b0, irq1}, 32'h1);
    check("R6 irq2 disabled", {31'b0, irq2}, 32'h0);
    rd(8'h18, 32'h1, "R5 rise sets line1");
    rd(8'h28, 32'h1, "R6 rise sets line2");
    wr(8'h2C, 32'h1);
    check("R6 irq2 after enable", {31'b0, irq2}, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h0, "R7 line1 cleared");
    rd(8'h28, 32'h1, "R7 line2 untouched by line1 clear");
    check("R7 irq1 low after clear", {31'b0, irq1}, 32'h0);
    check("R7 irq2 still high", {31'b0, irq2}, 32'h1);
    setpin(1, 1'b1);
    nap(2);
    rd(8'h18, 32'h0, "R5 rise on fall-only pin");
    setpin(1, 1'b0);
    nap(2);
    rd(8'h18, 32'h2, "R5 fall event");
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R7 edge bit stays clear");

    // R5 output pins ignored
    wr(8'h34, 32'hFFFF_FFFE);
    check("R3 pin_oe_n after write", pin_oe_n, 32'hFFFF_FFFE);
    setpin(0, 1'b0); setpin(0, 1'b1);
    nap(2);
    rd(8'h18, 32'h0, "R5 output pin no event");
    wr(8'h34, 32'hFFFF_FFFF);

    // R7 level detect re-assert
    wr(8'h44, 32'h8);
    nap(1);
    rd(8'h18, 32'h0, "R7 high level not present");
    setpin(3, 1'b1);
    nap(2);
    rd(8'h18, 32'h8, "R5 high-level event");
    wr(8'h18, 32'h8);
    rd(8'h18, 32'h8, "R7 level bit re-asserts");
    setpin(3, 1'b0);
    nap(1);
    wr(8'h18, 32'h8);
    rd(8'h18, 32'h0, "R7 level gone clears");
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h40, 32'h4);
    nap(1);
    rd(8'h18, 32'h4, "R7 low level after detect write");
    rd(8'h28, 32'h4, "R7 low level on line2");
    check("R6 irq1 from level", {31'b0, irq1}, 32'h1);
    wr(8'h40, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R7 clear after level off");

    // R9 wake gating
    wr(8'h48, 32'h11); wr(8'h84, 32'h10); wr(8'h10, 32'h0C);
    setpin(4, 1'b1);
    nap(1); check("R9 wake pulse", {31'b0, wake}, 32'h1);
    nap(1); check("R9 wake one cycle", {31'b0, wake}, 32'h0);
    setpin(4, 1'b0);
    wr(8'h10, 32'h04);
    setpin(4, 1'b1);
    nap(1); check("R9 idle 0 no wake", {31'b0, wake}, 32'h0);
    setpin(4, 1'b0);
    wr(8'h10, 32'h1C);
    rd(8'h10, 32'h1C, "R8 config readback");
    setpin(4, 1'b1);
    nap(1); check("R9 idle 3 no wake", {31'b0, wake}, 32'h0);
    setpin(4, 1'b0);
    wr(8'h10, 32'h10);
    setpin(4, 1'b1);
    nap(1); check("R9 bit2 off no wake", {31'b0, wake}, 32'h0);
    setpin(4, 1'b0);
    wr(8'h10, 32'h14); wr(8'h80, 32'h10);
    setpin(4, 1'b1);
    nap(1); check("R9 pin not wake-enabled", {31'b0, wake}, 32'h0);

    // R8 field widths
    wr(8'h10, 32'hFFFF_FFFD);
    rd(8'h10, 32'h1D, "R8 config mask");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h7, "R8 control width");
    wr(8'h54, 32'h1234);
    rd(8'h54, 32'h34, "R8 debounce time width");
    wr(8'h50, 32'hDEAD_BEEF);
    rd(8'h50, 32'hDEAD_BEEF, "R8 debounce enable");

    // R10 soft reset
    wr(8'h1C, 32'hFF); wr(8'h3C, 32'h55); wr(8'h34, 32'h0F);
    wr(8'h10, 32'h06);
    check("R10 pin_out cleared", pin_out, 32'h0);
    check("R10 pin_oe_n all inputs", pin_oe_n, 32'hFFFF_FFFF);
    rd(8'h10, 32'h04, "R10 config keeps written value");
    rd(8'h1C, 32'h0, "R10 enable cleared");
    rd(8'h18, 32'h0, "R10 status cleared");
    rd(8'h48, 32'h0, "R10 rise detect cleared");
    rd(8'h30, 32'h0, "R10 control cleared");
    rd(8'h00, 32'h18, "R10 identity kept");
    rd(8'h14, 32'h1, "R11 done after soft reset");
    check("R10 irq1 low", {31'b0, irq1}, 32'h0);

    for (int i = 0; i < 100 && exp_q.size() > 0; i++) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 responses missing actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule